// File: doc/BRIEF.md
# One-time-programmable array command engine

A register-mapped engine through which a processor reads rows of a one-time-programmable array and burns bits into them. Software sets an access bit, places a 6-bit command code and a row address in their registers, loads write data when programming, and then raises a start bit. The engine runs the command, raises a done flag in its status register and keeps it there until software drops the start bit. Only after that drop can a further command run.

The array is modelled as a register bank that resets to blank. A row is one 32-bit word or two, chosen by a parameter. Burning can only turn zeros into ones. Its duration grows with the number of ones in the written data, and a per-cycle countdown models that duration. The unlock handshake that makes burning legal is handled elsewhere and arrives on the `prog_enabled` input. The engine reports that input back in its status register.

Top module: `otp_cmd_engine`

## Requirements
- R1: After reset all registers read zero, the status register reads zero and every array row is blank (all zeros).
- R2: Bit 0 of the access register (offset 0x00) must be 1 for a start to take effect. When it is 0, raising start runs nothing and the done bit stays 0.
- R3: The command register (offset 0x04) keeps only the low 6 bits of a write and reads them back. Code 0x00 reads a row and code 0x0A programs a row. Any other code, including 0x02 and 0x03, is a no-op.
- R4: The row address register (offset 0x28) keeps only the low 16 bits of a write and reads them back.
- R5: A command starts only when a write of 1 to bit 0 of the start register (offset 0x08) finds that bit at 0. Writing 1 again while it is already 1 starts nothing. Status bit 1 (done, offset 0x0C) rises when the command completes and returns to 0 on the edge that writes 0 to the start bit. Done is never 1 while a command is running.
- R6: A read completes on the 3rd rising edge after the edge that wrote start. It then loads the low word of the row into the register at 0x10 and, with two-word rows, the high word into the register at 0x5C.
- R7: A program command ORs the write data (low word at 0x2C, high word at 0x64) into the addressed row, so a 1 is never cleared.
- R8: A program completes 4 + 2*N rising edges after the start edge, where N is the number of ones across the row's write data.
- R9: A program command that starts while `prog_enabled` is low leaves the array unchanged and completes after 1 edge.
- R10: The read-data registers change only when a read completes.
- R11: Status bit 2 reads 1 exactly when `prog_enabled` is high and the access bit is set.
- R12: A no-op command completes after 1 edge and changes neither the array nor the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| prog_enabled | input | 1 | Burning permitted, driven by the unlock block |

## Verification
The case hardest to reach from the ports is the worst burn. Every bit of a two-word row is set, so completion comes 132 edges after start, and done must be seen low on the edge before and high on the exact edge. The bench loads both write words with all ones, starts the program and counts negative edges to sample status on either side of that edge. It then reads the row back to show that the OR took effect. Start-level reuse and ignored programs are reached by issuing a second start without a falling start, and by dropping `prog_enabled` before a launch. In both cases the bench checks that done and the read-back row are unchanged.

// File: rtl/otp_pkg.sv
`timescale 1ns/1ps
package otp_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CMD_W  = 6;
  localparam int unsigned ROWA_W = 16;

  localparam logic [7:0] OFS_ACCESS = 8'h00;
  localparam logic [7:0] OFS_CMD    = 8'h04;
  localparam logic [7:0] OFS_START  = 8'h08;
  localparam logic [7:0] OFS_STATUS = 8'h0c;
  localparam logic [7:0] OFS_RD0    = 8'h10;
  localparam logic [7:0] OFS_ROWA   = 8'h28;
  localparam logic [7:0] OFS_WD0    = 8'h2c;
  localparam logic [7:0] OFS_RD1    = 8'h5c;
  localparam logic [7:0] OFS_WD1    = 8'h64;

  localparam logic [CMD_W-1:0] CMD_READ = 6'h00;
  localparam logic [CMD_W-1:0] CMD_PROG = 6'h0a;

  typedef enum logic [1:0] {OP_NOP, OP_READ, OP_PROG} op_e;

  function automatic logic [7:0] rd_ofs(input int unsigned w);
    return (w == 0) ? OFS_RD0 : OFS_RD1;
  endfunction

  function automatic logic [7:0] wd_ofs(input int unsigned w);
    return (w == 0) ? OFS_WD0 : OFS_WD1;
  endfunction
endpackage

// File: rtl/otp_regs.sv
`timescale 1ns/1ps
module otp_regs
  import otp_pkg::*;
#(
  parameter int unsigned ROW_WORDS = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [7:0]                           bus_addr,
  input  logic                                 bus_we,
  input  logic [WORD_W-1:0]                    bus_wdata,
  output logic [WORD_W-1:0]                    bus_rdata,
  input  logic                                 rd_load,
  input  logic [ROW_WORDS-1:0][WORD_W-1:0]     rd_row,
  input  logic                                 done,
  input  logic                                 prog_ok,
  output logic                                 access_on,
  output logic [CMD_W-1:0]                     cmd,
  output logic [ROWA_W-1:0]                    row_addr,
  output logic                                 start_lvl,
  output logic [ROW_WORDS-1:0][WORD_W-1:0]     wr_row,
  output logic                                 launch_req,
  output logic                                 start_clr
);
  logic                             access_q, access_d;
  logic [CMD_W-1:0]                 cmd_q, cmd_d;
  logic [ROWA_W-1:0]                rowa_q, rowa_d;
  logic                             start_q, start_d;
  logic [ROW_WORDS-1:0][WORD_W-1:0] wd_q, wd_d;
  logic [ROW_WORDS-1:0][WORD_W-1:0] rd_q, rd_d;
  logic                             wr_start;

  assign wr_start   = bus_we && (bus_addr == OFS_START);
  assign launch_req = wr_start && bus_wdata[0] && !start_q && access_q;
  assign start_clr  = wr_start && !bus_wdata[0];

  always_comb begin
    access_d = access_q;
    cmd_d    = cmd_q;
    rowa_d   = rowa_q;
    start_d  = start_q;
    if (bus_we && bus_addr == OFS_ACCESS) access_d = bus_wdata[0];
    if (bus_we && bus_addr == OFS_CMD)    cmd_d    = bus_wdata[CMD_W-1:0];
    if (bus_we && bus_addr == OFS_ROWA)   rowa_d   = bus_wdata[ROWA_W-1:0];
    if (wr_start)                         start_d  = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      access_q <= 1'b0;
      cmd_q    <= '0;
      rowa_q   <= '0;
      start_q  <= 1'b0;
    end else begin
      access_q <= access_d;
      cmd_q    <= cmd_d;
      rowa_q   <= rowa_d;
      start_q  <= start_d;
    end
  end

  for (genvar w = 0; w < ROW_WORDS; w++) begin : g_word
    localparam logic [7:0] WOFS = wd_ofs(w);
    logic wd_en;
    assign wd_en = bus_we && (bus_addr == WOFS);

    always_comb begin
      wd_d[w] = wd_en ? bus_wdata : wd_q[w];
      rd_d[w] = rd_load ? rd_row[w] : rd_q[w];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wd_q[w] <= '0;
        rd_q[w] <= '0;
      end else begin
        if (wd_en)   wd_q[w] <= wd_d[w];
        if (rd_load) rd_q[w] <= rd_d[w];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_ACCESS: bus_rdata = {{(WORD_W-1){1'b0}}, access_q};
      OFS_CMD:    bus_rdata = {{(WORD_W-CMD_W){1'b0}}, cmd_q};
      OFS_START:  bus_rdata = {{(WORD_W-1){1'b0}}, start_q};
      OFS_STATUS: bus_rdata = {{(WORD_W-3){1'b0}}, prog_ok, done, 1'b0};
      OFS_ROWA:   bus_rdata = {{(WORD_W-ROWA_W){1'b0}}, rowa_q};
      OFS_RD0:    bus_rdata = rd_q[0];
      OFS_WD0:    bus_rdata = wd_q[0];
      OFS_RD1:    bus_rdata = (ROW_WORDS > 1) ? rd_q[ROW_WORDS-1] : '0;
      OFS_WD1:    bus_rdata = (ROW_WORDS > 1) ? wd_q[ROW_WORDS-1] : '0;
      default:    bus_rdata = '0;
    endcase
  end

  assign access_on = access_q;
  assign cmd       = cmd_q;
  assign row_addr  = rowa_q;
  assign start_lvl = start_q;
  assign wr_row    = wd_q;
endmodule

// File: rtl/otp_seq.sv
`timescale 1ns/1ps
module otp_seq
  import otp_pkg::*;
#(
  parameter int unsigned ROW_BITS     = 64,
  parameter int unsigned READ_LAT     = 3,
  parameter int unsigned PROG_BASE    = 4,
  parameter int unsigned PROG_PER_BIT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch_req,
  input  logic                start_clr,
  input  logic                start_lvl,
  input  logic [CMD_W-1:0]    cmd,
  input  logic [ROWA_W-1:0]   row_addr,
  input  logic [ROW_BITS-1:0] wr_row,
  input  logic                prog_enabled,
  output logic                busy,
  output logic                done,
  output logic                accept,
  output logic                rd_load,
  output logic                prog_we,
  output logic [ROWA_W-1:0]   cap_addr,
  output logic [ROW_BITS-1:0] cap_row
);
  localparam int unsigned MAX_LAT = PROG_BASE + PROG_PER_BIT * ROW_BITS;
  localparam int unsigned CNT_W   = $clog2(MAX_LAT + 1);

  logic                busy_q, busy_d;
  logic                done_q, done_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  op_e                 op_q, op_d;
  logic [ROWA_W-1:0]   addr_q, addr_d;
  logic [ROW_BITS-1:0] row_q, row_d;
  logic [CNT_W-1:0]    ones;
  logic                finish;

  always_comb begin
    ones = '0;
    for (int i = 0; i < ROW_BITS; i++) ones = ones + CNT_W'(wr_row[i]);
  end

  assign accept = launch_req && !busy_q;
  assign finish = busy_q && (cnt_q == CNT_W'(1));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    addr_d = addr_q;
    row_d  = row_q;
    if (accept) begin
      busy_d = 1'b1;
      addr_d = row_addr;
      row_d  = wr_row;
      if (cmd == CMD_READ) begin
        op_d  = OP_READ;
        cnt_d = CNT_W'(READ_LAT);
      end else if (cmd == CMD_PROG && prog_enabled) begin
        op_d  = OP_PROG;
        cnt_d = CNT_W'(PROG_BASE) + CNT_W'(PROG_PER_BIT) * ones;
      end else begin
        op_d  = OP_NOP;
        cnt_d = CNT_W'(1);
      end
    end else if (finish) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_comb begin
    done_d = done_q;
    if (start_clr)                done_d = 1'b0;
    else if (finish && start_lvl) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_NOP;
      addr_q <= '0;
      row_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      if (accept) begin
        addr_q <= addr_d;
        row_q  <= row_d;
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rd_load  = finish && (op_q == OP_READ);
  assign prog_we  = finish && (op_q == OP_PROG);
  assign cap_addr = addr_q;
  assign cap_row  = row_q;
endmodule

// File: rtl/otp_array.sv
`timescale 1ns/1ps
module otp_array #(
  parameter int unsigned ROW_BITS = 64,
  parameter int unsigned DEPTH    = 32,
  localparam int unsigned IDX_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                burn,
  input  logic [IDX_W-1:0]    idx,
  input  logic [ROW_BITS-1:0] burn_bits,
  output logic [ROW_BITS-1:0] row_out
);
  logic [DEPTH-1:0][ROW_BITS-1:0] cell_q;

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic                en;
    logic [ROW_BITS-1:0] nxt;
    assign en  = burn && (idx == IDX_W'(r));
    assign nxt = cell_q[r] | burn_bits;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cell_q[r] <= '0;
      else if (en) cell_q[r] <= nxt;
    end
  end

  assign row_out = cell_q[idx];
endmodule

// File: rtl/otp_cmd_engine.sv
`timescale 1ns/1ps
module otp_cmd_engine
  import otp_pkg::*;
#(
  parameter int unsigned ROW_WORDS = 2,
  parameter int unsigned DEPTH     = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        prog_enabled
);
  localparam int unsigned ROW_BITS = WORD_W * ROW_WORDS;
  localparam int unsigned IDX_W    = $clog2(DEPTH);

  logic                             rst_meta, rst_sync_n;
  logic                             access_on, start_lvl, launch_req, start_clr;
  logic [CMD_W-1:0]                 cmd;
  logic [ROWA_W-1:0]                row_addr, cap_addr;
  logic [ROW_WORDS-1:0][WORD_W-1:0] wr_row, rd_row;
  logic [ROW_BITS-1:0]              cap_row, row_out;
  logic                             busy, done, accept, rd_load, prog_we, prog_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign prog_ok = prog_enabled && access_on;
  assign rd_row  = row_out;

  otp_regs #(.ROW_WORDS(ROW_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_load(rd_load), .rd_row(rd_row), .done(done), .prog_ok(prog_ok),
    .access_on(access_on), .cmd(cmd), .row_addr(row_addr), .start_lvl(start_lvl),
    .wr_row(wr_row), .launch_req(launch_req), .start_clr(start_clr)
  );

  otp_seq #(.ROW_BITS(ROW_BITS)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .launch_req(launch_req), .start_clr(start_clr), .start_lvl(start_lvl),
    .cmd(cmd), .row_addr(row_addr), .wr_row(wr_row), .prog_enabled(prog_enabled),
    .busy(busy), .done(done), .accept(accept), .rd_load(rd_load), .prog_we(prog_we),
    .cap_addr(cap_addr), .cap_row(cap_row)
  );

  otp_array #(.ROW_BITS(ROW_BITS), .DEPTH(DEPTH)) u_array (
    .clk(clk), .rst_n(rst_sync_n),
    .burn(prog_we), .idx(cap_addr[IDX_W-1:0]), .burn_bits(cap_row), .row_out(row_out)
  );
endmodule

// File: rtl/otp_cmd_engine_chk.sv
`timescale 1ns/1ps
module otp_cmd_engine_chk
  import otp_pkg::*;
#(
  parameter int unsigned ROW_BITS = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic [7:0]          bus_addr,
  input logic                bus_we,
  input logic [31:0]         bus_wdata,
  input logic                access_on,
  input logic                busy,
  input logic                done,
  input logic                accept,
  input logic [CMD_W-1:0]    cmd,
  input logic                rd_load,
  input logic                prog_we,
  input logic [ROW_BITS-1:0] row_out,
  input logic [ROW_BITS-1:0] rd_held
);
  // R2: a start with access off launches nothing
  a_r2_no_launch_without_access: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_START && bus_wdata[0] && !access_on && !busy) |=> !busy);

  // R5: dropping start clears done on the same edge
  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_START && !bus_wdata[0]) |=> !done);

  // R5: done is never raised while a command runs
  a_r5_done_low_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  // R6: a read completes three edges after acceptance
  a_r6_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |-> $past(accept && cmd == CMD_READ, 3));

  // R7: burning keeps every bit that was already set
  a_r7_no_bit_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |=> ((row_out & $past(row_out)) == $past(row_out)));

  // R10: read data holds between read completions
  a_r10_read_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_load |=> $stable(rd_held));
endmodule

bind otp_cmd_engine otp_cmd_engine_chk #(.ROW_BITS(ROW_BITS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .access_on(access_on), .busy(busy), .done(done), .accept(accept), .cmd(cmd),
  .rd_load(rd_load), .prog_we(prog_we), .row_out(row_out), .rd_held(u_regs.rd_q)
);

// File: tb/otp_cmd_engine_bench.sv
`timescale 1ns/1ps
module otp_cmd_engine_bench;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        prog_enabled;
  int          n_checks = 0;
  int          n_errors = 0;

  otp_cmd_engine u_otp_cmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prog_enabled(prog_enabled)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic launch(input logic [31:0] c, input logic [31:0] row);
    wr(8'h04, c);
    wr(8'h28, row);
    wr(8'h08, 32'h1);
  endtask

  task automatic expect_done_at(input int lat, input string tag);
    logic [31:0] s;
    repeat (lat - 1) @(negedge clk);
    rd(8'h0c, s);
    check({31'b0, s[1]}, 32'h0, {tag, " done one edge early"});
    @(negedge clk);
    rd(8'h0c, s);
    check({31'b0, s[1]}, 32'h1, {tag, " done on exact edge"});
  endtask

  task automatic clear_start(input string tag);
    logic [31:0] s;
    wr(8'h08, 32'h0);
    rd(8'h0c, s);
    check({31'b0, s[1]}, 32'h0, {tag, " done cleared by start drop"});
  endtask

  task automatic read_row(input logic [31:0] row, output logic [31:0] lo, output logic [31:0] hi);
    launch(32'h00, row);
    expect_done_at(3, "R6 read");
    clear_start("R5");
    rd(8'h10, lo);
    rd(8'h5c, hi);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h0c, v); check(v, 32'h0, "R1 status after reset");
    rd(8'h00, v); check(v, 32'h0, "R1 access after reset");
    rd(8'h10, v); check(v, 32'h0, "R1 read data after reset");
    rd(8'h2c, v); check(v, 32'h0, "R1 write data after reset");
  endtask

  task automatic t_no_access;
    logic [31:0] v;
    prog_enabled = 1'b1;
    rd(8'h0c, v); check({31'b0, v[2]}, 32'h0, "R11 prog ok low without access");
    launch(32'h00, 32'h0);
    repeat (5) @(negedge clk);
    rd(8'h0c, v); check({31'b0, v[1]}, 32'h0, "R2 no done without access");
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h1);
    rd(8'h0c, v); check({31'b0, v[2]}, 32'h1, "R11 prog ok with access");
  endtask

  task automatic t_masks;
    logic [31:0] v;
    wr(8'h28, 32'habcd1234); rd(8'h28, v); check(v, 32'h00001234, "R4 address masked");
    wr(8'h04, 32'h00000c0a); rd(8'h04, v); check(v, 32'h0000000a, "R3 command masked");
  endtask

  task automatic t_blank_read;
    logic [31:0] lo, hi;
    read_row(32'h3, lo, hi);
    check(lo, 32'h0, "R6 blank row low"); check(hi, 32'h0, "R6 blank row high");
  endtask

  task automatic t_program;
    logic [31:0] v, lo, hi;
    wr(8'h2c, 32'h00000003); wr(8'h64, 32'h00000001);
    launch(32'h0a, 32'h3);
    expect_done_at(10, "R8 three ones");
    clear_start("R5");
    rd(8'h10, v); check(v, 32'h0, "R10 read data unchanged by program");
    read_row(32'h3, lo, hi);
    check(lo, 32'h3, "R7 programmed low"); check(hi, 32'h1, "R7 programmed high");
    wr(8'h2c, 32'h00000010); wr(8'h64, 32'h0);
    launch(32'h0a, 32'h3);
    expect_done_at(6, "R8 one one");
    clear_start("R5");
    read_row(32'h3, lo, hi);
    check(lo, 32'h13, "R7 OR low"); check(hi, 32'h1, "R7 OR keeps high");
  endtask

  task automatic t_start_held;
    logic [31:0] v;
    launch(32'h00, 32'h3);
    expect_done_at(3, "R6 read");
    wr(8'h28, 32'h5);
    wr(8'h08, 32'h1);
    repeat (6) @(negedge clk);
    rd(8'h0c, v); check({31'b0, v[1]}, 32'h1, "R5 held start keeps done");
    rd(8'h10, v); check(v, 32'h13, "R5 held start runs no read");
    clear_start("R5");
  endtask

  task automatic t_prog_disabled;
    logic [31:0] lo, hi;
    prog_enabled = 1'b0;
    #1;
    rd(8'h0c, lo); check({31'b0, lo[2]}, 32'h0, "R11 prog ok follows input");
    wr(8'h2c, 32'hffff0000); wr(8'h64, 32'hffffffff);
    launch(32'h0a, 32'h3);
    expect_done_at(1, "R9 ignored program");
    clear_start("R5");
    read_row(32'h3, lo, hi);
    check(lo, 32'h13, "R9 row low unchanged"); check(hi, 32'h1, "R9 row high unchanged");
    prog_enabled = 1'b1;
  endtask

  task automatic t_all_ones;
    logic [31:0] lo, hi;
    wr(8'h2c, 32'hffffffff); wr(8'h64, 32'hffffffff);
    launch(32'h0a, 32'h7);
    expect_done_at(132, "R8 all ones");
    clear_start("R5");
    read_row(32'h7, lo, hi);
    check(lo, 32'hffffffff, "R7 all ones low"); check(hi, 32'hffffffff, "R7 all ones high");
  endtask

  task automatic t_noop;
    logic [31:0] lo, hi;
    wr(8'h2c, 32'h00000100); wr(8'h64, 32'h0);
    launch(32'h02, 32'h9);
    expect_done_at(1, "R12 no-op");
    clear_start("R12");
    rd(8'h10, lo); check(lo, 32'hffffffff, "R12 read data untouched");
    read_row(32'h9, lo, hi);
    check(lo, 32'h0, "R12 row untouched");
    wr(8'h04, 32'h00000c0a);
    wr(8'h08, 32'h1);
    expect_done_at(4 + 2, "R3 masked code programs");
    clear_start("R3");
    read_row(32'h9, lo, hi);
    check(lo, 32'h100, "R3 masked program result");
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; prog_enabled = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_no_access();
    t_masks();
    t_blank_read();
    t_program();
    t_start_held();
    t_prog_disabled();
    t_all_ones();
    t_noop();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule